// File: doc/BRIEF.md
# Self-Synchronizing Block Scrambler Pair

This block holds the two halves of a multiplicative scrambler for 66-bit line blocks: a transmit scrambler and a receive descrambler, each working on a whole 64-bit payload in one clock. Both use the generator 1 + x^39 + x^58. The transmit half feeds back its own output bits into a 58-bit history. The receive half feeds the bits it receives into its history, so it falls into step with any scrambler after one block, with no seed exchanged. The 2-bit sync header of each block goes through unchanged, alongside its payload.

A valid strobe on each side marks the cycles that carry a block. Only those cycles move the history and the outputs. The receive side also raises a sticky status flag once it has taken in enough bits to fill its history. From then on the payload it puts out is the true descrambled payload. Line coding, block alignment and the transceiver lie outside this block.

Top module: `scr_pair`

## Requirements
- R1: On each accepted block the transmit side produces payload bit i as in[i] XOR t(39) XOR t(58), where t(k) is the transmit output bit k positions earlier in time. The history runs across block boundaries.
- R2: Payload bit 0 is first in time and bit 63 last. From an all-zero history, a block with only bit 0 set scrambles to a payload with exactly bits 0, 39 and 58 set.
- R3: The receive side produces payload bit i as in[i] XOR r(39) XOR r(58), where r(k) is the received bit k positions earlier in time.
- R4: Scrambling a stream that starts from any history and then descrambling it returns the original payload for every block after the first one the receive side accepts.
- R5: The 2-bit header of an accepted block appears unchanged on the output, in the same cycle as that block's payload.
- R6: Each direction has a latency of one clock. An input block accepted at a clock edge appears on the outputs after that edge, and the output valid equals the input valid from the previous cycle.
- R7: While valid is low, the history, the output payload and the output header hold their values. The next accepted block is processed as if the idle cycles had not occurred.
- R8: The receive status flag goes high at the clock edge that brings the count of received bits since reset to 58 or more. With 64-bit payloads this is the edge that accepts the first block. The flag then stays high until reset.
- R9: While rst_n is low (active low, synchronous), both histories clear to zero, all outputs go to zero and the status flag goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_vld_i | input | 1 | Transmit block valid |
| tx_hdr_i | input | 2 | Transmit sync header |
| tx_pay_i | input | 64 | Transmit payload, bit 0 first in time |
| tx_vld_o | output | 1 | Scrambled block valid |
| tx_hdr_o | output | 2 | Header passed through |
| tx_pay_o | output | 64 | Scrambled payload |
| rx_vld_i | input | 1 | Received block valid |
| rx_hdr_i | input | 2 | Received sync header |
| rx_pay_i | input | 64 | Received scrambled payload |
| rx_vld_o | output | 1 | Descrambled block valid |
| rx_hdr_o | output | 2 | Header passed through |
| rx_pay_o | output | 64 | Descrambled payload |
| rx_locked_o | output | 1 | Receive history filled since reset |

## Verification
The bench builds the block with its default parameters: a 64-bit payload, a 58-bit history and the tap at 39. Because the payload is wider than the history, a single accepted block flushes the receive history completely. This lets the bench show that the status flag rises after one block and that the recovered payload is exact from the second block on. The bench also starts the scrambler from an arbitrary nonzero history. The 39-bit tap lands inside the same block as the bit that feeds it, so the single-bit impulse test shows both the bit order in time and the feedback within one cycle.

// File: rtl/scr_pkg.sv
// Shared constants for the scrambler pair.
// Assumes the payload is processed LSB-first (bit 0 oldest in time).
package scr_pkg;
    localparam int unsigned PAY_W  = 64;  // payload bits per block
    localparam int unsigned HDR_W  = 2;   // sync header bits
    localparam int unsigned HIST_W = 58;  // highest generator power
    localparam int unsigned TAP_W  = 39;  // inner generator power

    // Selects which bit stream is fed back into the history.
    typedef enum logic {
        FB_OUTPUT = 1'b0,  // scrambler: own output bits
        FB_INPUT  = 1'b1   // descrambler: received bits
    } fb_sel_e;
endpackage

// File: rtl/scr_stage.sv
// One registered scrambling stage. It processes a whole payload per clock
// through 1 + x^TAP + x^HIST. FB picks whether the output bits (scramble)
// or the input bits (descramble) enter the history. The header is carried
// alongside. Assumes TAP < HIST. Everything updates only when vld_i is high.
module scr_stage
    import scr_pkg::*;
#(
    parameter int unsigned DW   = PAY_W,
    parameter int unsigned HW   = HDR_W,
    parameter int unsigned SW   = HIST_W,
    parameter int unsigned TW   = TAP_W,
    parameter fb_sel_e     FB   = FB_OUTPUT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_i,
    input  logic [HW-1:0] hdr_i,
    input  logic [DW-1:0] pay_i,
    output logic          vld_o,
    output logic [HW-1:0] hdr_o,
    output logic [DW-1:0] pay_o
);
    localparam int unsigned EW = SW + DW;  // history followed by new bits

    logic [SW-1:0] hist_q;   // time order: [SW-1] is the most recent bit
    logic [EW-1:0] ext;
    logic [DW-1:0] res;

    // Unrolled bit-serial recurrence over the extended bit stream.
    always_comb begin
        ext          = '0;
        res          = '0;
        ext[SW-1:0]  = hist_q;
        for (int i = 0; i < DW; i++) begin
            res[i] = pay_i[i] ^ ext[SW + i - TW] ^ ext[i];
            if (FB == FB_OUTPUT) begin
                ext[SW + i] = res[i];
            end else begin
                ext[SW + i] = pay_i[i];
            end
        end
    end

    // Register results and advance the history on accepted blocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            vld_o  <= 1'b0;
            hdr_o  <= '0;
            pay_o  <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                hist_q <= ext[EW-1 -: SW];
                hdr_o  <= hdr_i;
                pay_o  <= res;
            end
        end
    end
endmodule

// File: rtl/scr_sync_mon.sv
// Counts received bits since reset and flags when the descrambler history
// holds only received bits. The count saturates once the threshold is met,
// so the flag is sticky until reset.
module scr_sync_mon
    import scr_pkg::*;
#(
    parameter int unsigned DW = PAY_W,
    parameter int unsigned SW = HIST_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld_i,
    output logic locked_o
);
    localparam int unsigned CW = $clog2(SW + DW + 1);
    localparam logic [CW-1:0] THR  = CW'(SW);
    localparam logic [CW-1:0] STEP = CW'(DW);

    logic [CW-1:0] cnt_q;

    // Accumulate received bits until the threshold is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (vld_i && (cnt_q < THR)) begin
            cnt_q <= cnt_q + STEP;
        end
    end

    assign locked_o = (cnt_q >= THR);
endmodule

// File: rtl/scr_pair.sv
// Transmit scrambler and receive descrambler for 66-bit blocks, with
// a receive status flag. The two directions share only clock and reset.
module scr_pair
    import scr_pkg::*;
#(
    parameter int unsigned DW = PAY_W,
    parameter int unsigned HW = HDR_W,
    parameter int unsigned SW = HIST_W,
    parameter int unsigned TW = TAP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_vld_i,
    input  logic [HW-1:0] tx_hdr_i,
    input  logic [DW-1:0] tx_pay_i,
    output logic          tx_vld_o,
    output logic [HW-1:0] tx_hdr_o,
    output logic [DW-1:0] tx_pay_o,
    input  logic          rx_vld_i,
    input  logic [HW-1:0] rx_hdr_i,
    input  logic [DW-1:0] rx_pay_i,
    output logic          rx_vld_o,
    output logic [HW-1:0] rx_hdr_o,
    output logic [DW-1:0] rx_pay_o,
    output logic          rx_locked_o
);
    scr_stage #(.DW(DW), .HW(HW), .SW(SW), .TW(TW), .FB(FB_OUTPUT)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .vld_i(tx_vld_i), .hdr_i(tx_hdr_i), .pay_i(tx_pay_i),
        .vld_o(tx_vld_o), .hdr_o(tx_hdr_o), .pay_o(tx_pay_o)
    );

    scr_stage #(.DW(DW), .HW(HW), .SW(SW), .TW(TW), .FB(FB_INPUT)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .vld_i(rx_vld_i), .hdr_i(rx_hdr_i), .pay_i(rx_pay_i),
        .vld_o(rx_vld_o), .hdr_o(rx_hdr_o), .pay_o(rx_pay_o)
    );

    scr_sync_mon #(.DW(DW), .SW(SW)) u_mon (
        .clk(clk), .rst_n(rst_n), .vld_i(rx_vld_i), .locked_o(rx_locked_o)
    );
endmodule

// File: rtl/scr_pair_chk.sv
// Port-level temporal checks for scr_pair, attached by bind.
module scr_pair_chk #(
    parameter int unsigned DW = 64,
    parameter int unsigned HW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_vld_i,
    input logic [HW-1:0] tx_hdr_i,
    input logic          tx_vld_o,
    input logic [HW-1:0] tx_hdr_o,
    input logic [DW-1:0] tx_pay_o,
    input logic          rx_vld_i,
    input logic [HW-1:0] rx_hdr_i,
    input logic          rx_vld_o,
    input logic [HW-1:0] rx_hdr_o,
    input logic [DW-1:0] rx_pay_o,
    input logic          rx_locked_o
);
    AST_TX_HDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_vld_i |=> tx_hdr_o == $past(tx_hdr_i));                 // R5
    AST_RX_HDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_vld_i |=> rx_hdr_o == $past(rx_hdr_i));                 // R5
    AST_TX_VLD_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_vld_i |=> tx_vld_o);                                    // R6
    AST_RX_VLD_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_vld_i |=> !rx_vld_o);                                  // R6
    AST_TX_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_vld_i |=> $stable(tx_pay_o) && $stable(tx_hdr_o));     // R7
    AST_RX_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_vld_i |=> $stable(rx_pay_o) && $stable(rx_hdr_o));     // R7
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_locked_o |=> rx_locked_o);                              // R8
    AST_LOCK_NEEDS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_locked_o) |-> $past(rx_vld_i));                   // R8
endmodule

bind scr_pair scr_pair_chk #(.DW(DW), .HW(HW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .tx_vld_i(tx_vld_i), .tx_hdr_i(tx_hdr_i),
    .tx_vld_o(tx_vld_o), .tx_hdr_o(tx_hdr_o), .tx_pay_o(tx_pay_o),
    .rx_vld_i(rx_vld_i), .rx_hdr_i(rx_hdr_i),
    .rx_vld_o(rx_vld_o), .rx_hdr_o(rx_hdr_o), .rx_pay_o(rx_pay_o),
    .rx_locked_o(rx_locked_o)
);

// File: tb/scr_pair_test.sv
// Directed bench for scr_pair with bit-serial reference models.
module scr_pair_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_vld_i = 1'b0, rx_vld_i = 1'b0;
    logic [1:0]  tx_hdr_i = '0, rx_hdr_i = '0;
    logic [63:0] tx_pay_i = '0, rx_pay_i = '0;
    logic        tx_vld_o, rx_vld_o, rx_locked_o;
    logic [1:0]  tx_hdr_o, rx_hdr_o;
    logic [63:0] tx_pay_o, rx_pay_o;

    int total = 0;
    int bad = 0;
    logic [57:0] m_tx, m_rx;   // [0] newest bit
    logic [63:0] lcg = 64'h0123_4567_89AB_CDEF;

    scr_pair uut (.*);

    always #(CLK_P/2) clk = ~clk;

    initial begin
        #(CLK_P * 150000);
        bad++; total++;
        $display("FAIL watchdog: expired, actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic mdl_scr(input logic [63:0] d, output logic [63:0] q);
        for (int i = 0; i < 64; i++) begin
            q[i] = d[i] ^ m_tx[38] ^ m_tx[57];
            m_tx = {m_tx[56:0], q[i]};
        end
    endtask

    task automatic mdl_dscr(input logic [63:0] d, output logic [63:0] q);
        for (int i = 0; i < 64; i++) begin
            q[i] = d[i] ^ m_rx[38] ^ m_rx[57];
            m_rx = {m_rx[56:0], d[i]};
        end
    endtask

    function automatic logic [63:0] nxt();
        lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
        return lcg;
    endfunction

    // Drive one cycle on both sides, sample after the edge.
    task automatic cyc(input logic tv, input logic [1:0] th, input logic [63:0] td,
                       input logic rv, input logic [1:0] rh, input logic [63:0] rd);
        @(negedge clk);
        tx_vld_i = tv; tx_hdr_i = th; tx_pay_i = td;
        rx_vld_i = rv; rx_hdr_i = rh; rx_pay_i = rd;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tx_vld_i = 0; rx_vld_i = 0;
        repeat (3) @(posedge clk);
        #1;
        m_tx = '0; m_rx = '0;
    endtask

    task automatic t_reset();
        do_reset();
        chk(tx_pay_o == 0 && rx_pay_o == 0, "R9 payloads", tx_pay_o | rx_pay_o, 0);
        chk(!tx_vld_o && !rx_vld_o && tx_hdr_o == 0 && rx_hdr_o == 0,
            "R9 valid/hdr", {tx_vld_o, rx_vld_o, tx_hdr_o, rx_hdr_o}, 0);
        chk(!rx_locked_o, "R9 lock low", rx_locked_o, 0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_impulse();
        logic [63:0] e;
        mdl_scr(64'h1, e);
        cyc(1, 2'b01, 64'h1, 0, 0, 0);
        chk(tx_pay_o == ((64'h1 << 58) | (64'h1 << 39) | 64'h1), "R2 impulse",
            tx_pay_o, (64'h1 << 58) | (64'h1 << 39) | 64'h1);
        chk(tx_pay_o == e, "R1 impulse model", tx_pay_o, e);
    endtask

    task automatic t_tx_stream();
        logic [63:0] d, e;
        logic [63:0] pats [4] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0,
                                  64'hAAAA_5555_F0F0_0F0F, 64'h8000_0000_0000_0001};
        for (int k = 0; k < 12; k++) begin
            d = (k < 4) ? pats[k] : nxt();
            mdl_scr(d, e);
            // R6: before the edge the output still holds the previous block
            @(negedge clk);
            tx_vld_i = 1; tx_hdr_i = 2'(k + 1); tx_pay_i = d;
            #1;
            if (k == 2) chk(tx_pay_o != e || e == 0, "R6 not early", tx_pay_o, ~e);
            @(posedge clk); #1;
            chk(tx_pay_o == e, "R1 stream", tx_pay_o, e);
            chk(tx_hdr_o == 2'(k + 1), "R5 tx hdr", 64'(tx_hdr_o), 64'(2'(k + 1)));
            chk(tx_vld_o, "R6 tx valid", 64'(tx_vld_o), 1);
        end
    endtask

    task automatic t_idle();
        logic [63:0] held, e, d;
        held = tx_pay_o;
        for (int k = 0; k < 3; k++) begin
            cyc(0, 2'b11, nxt(), 0, 0, 0);
            chk(tx_pay_o == held, "R7 hold", tx_pay_o, held);
            chk(!tx_vld_o, "R6 valid low", 64'(tx_vld_o), 0);
        end
        d = nxt();
        mdl_scr(d, e);
        cyc(1, 2'b10, d, 0, 0, 0);
        chk(tx_pay_o == e, "R7 resume", tx_pay_o, e);
    endtask

    task automatic t_rx_sync();
        logic [63:0] d, s, e, q;
        do_reset();
        @(negedge clk); rst_n = 1'b1;
        m_tx = 58'h2A5_F00D_1234_5678;          // arbitrary scrambler history
        chk(!rx_locked_o, "R8 low before data", rx_locked_o, 0);
        for (int k = 0; k < 8; k++) begin
            d = nxt();
            mdl_scr(d, s);
            mdl_dscr(s, e);
            cyc(0, 0, 0, 1, 2'b10, s);
            chk(rx_pay_o == e, "R3 rx model", rx_pay_o, e);
            chk(rx_hdr_o == 2'b10, "R5 rx hdr", 64'(rx_hdr_o), 2);
            chk(rx_locked_o, "R8 lock after block", rx_locked_o, 1);
            if (k > 0) chk(rx_pay_o == d, "R4 recovered", rx_pay_o, d);
        end
        q = rx_pay_o;
        cyc(0, 0, 0, 0, 2'b01, nxt());
        chk(rx_pay_o == q && rx_locked_o, "R7 rx hold", rx_pay_o, q);
        do_reset();
        chk(!rx_locked_o, "R9 lock cleared", rx_locked_o, 0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_loop();
        logic [63:0] d [6];
        for (int k = 0; k < 6; k++) d[k] = nxt();
        // feed the transmit output straight into the receive input
        cyc(1, 2'b01, d[0], 0, 0, 0);
        for (int k = 1; k <= 6; k++) begin
            cyc(k < 6, 2'b01, (k < 6) ? d[k] : 64'h0, 1, tx_hdr_o, tx_pay_o);
            chk(rx_pay_o == d[k-1], "R4 loopback", rx_pay_o, d[k-1]);
        end
    endtask

    initial begin
        t_reset();
        t_impulse();
        t_tx_stream();
        t_idle();
        t_rx_sync();
        t_loop();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule